// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit-Slot Engine

This block is the bit-level slave on a single-wire, open-drain serial bus. A system clock runs it, and a one-cycle strobe marks each elapsed microsecond. All bus timing is counted in those ticks. The wire comes in as a raw sampled level. The block pulls the wire down through an active-low enable, so a 0 on that output grounds the line.

The engine tracks one bus transaction at a time. When the host holds the line low long enough to signal a bus reset, the engine answers with a presence pulse once the host releases the line. When the host writes a bit, the engine reads the line in the middle of the slot and collects the bits into bytes, least-significant bit first. When the layer above selects transmit mode, each host slot becomes a read slot. In a read slot the engine asks for the next bit, and for a 0 it holds the line low until a fixed point in the slot. A short spike on the line is treated as noise and does not start a slot.

Top module: `swbus_slot_slave`

## Requirements
- R1: When the line has been low for RST_US (default 480) consecutive microsecond ticks, `rstSeen` pulses for one cycle. The reset also ends any slot in progress.
- R2: After a reset, once the host releases the line, `pullN` goes low after PD_WAIT_US (default 30, which lies within 15–60) ticks. It then stays low for PD_LOW_US (default 120, which lies within 60–240) ticks and is released.
- R3: In a receive slot, the line is sampled SAMPLE_US (default 30) ticks after the falling edge. A high line gives bit value 1 and a low line gives 0. The value appears on `rxBit` together with a one-cycle `rxBitStb`.
- R4: Received bits fill a byte least-significant bit first. On the eighth bit, `rxByte` takes the assembled value and `rxByteStb` pulses in the same cycle as that bit's `rxBitStb`.
- R5: When `txMode` is 1, each slot pulses `txReq` once. If `txBit` is 0, `pullN` is held low from the start of the slot until HOLD_US (default 15) ticks after the falling edge, and is then released. If `txBit` is 1, `pullN` stays high.
- R6: A low pulse that ends before the next microsecond tick after it began is ignored. It produces no bit strobe, no transmit request and no pull-down, and it does not advance the byte position.
- R7: A reset discards any partly received byte, so the next byte is assembled from bit position 0.
- R8: After the system reset (`rstN` low), `pullN` is 1 and `rstSeen`, `txReq`, `rxBitStb` and `rxByteStb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| usTick | input | 1 | One-cycle strobe each microsecond |
| lineIn | input | 1 | Raw sampled level of the bus wire |
| txMode | input | 1 | 1: slots are slave-transmit slots |
| txBit | input | 1 | Bit to send in the next transmit slot |
| pullN | output | 1 | Active-low pull-down enable for the wire |
| rstSeen | output | 1 | Pulse: host bus reset detected |
| txReq | output | 1 | Pulse: transmit slot started, `txBit` consumed |
| rxBitStb | output | 1 | Pulse: a received bit is valid on `rxBit` |
| rxBit | output | 1 | Last received bit value |
| rxByteStb | output | 1 | Pulse: `rxByte` holds a new byte |
| rxByte | output | DATA_W | Last assembled byte, LSB received first |

## Verification
The hardest case to reach is a spike that falls between two microsecond ticks. Whether such a pulse counts as a glitch depends on where it lands relative to the tick, which the ports do not show directly. The bench generates the tick itself and places a three-clock low pulse right after a tick. It does this in the middle of a byte, then checks that no strobe or pull-down appeared and that the byte still assembles correctly. Aborting a partly received byte is reached the same way: the bench sends a few bits, issues a reset, and then sends a full byte.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_WSLOT,
    ST_RSLOT,
    ST_WAITHI,
    ST_RSTWAIT,
    ST_PDWAIT,
    ST_PDLOW
  } slotState_t;

  typedef struct packed {
    logic clrTimer;
    logic sample;
    logic driveOn;
    logic driveOff;
    logic clrByte;
  } ctlStrobe_t;

endpackage

// File: rtl/swbus_slot_dp.sv
module swbus_slot_dp
  import swbus_pkg::*;
#(
  parameter int RST_US = 480,
  parameter int SLOT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              lineIn,
  input  ctlStrobe_t        ctl,
  output logic              lineLow,
  output logic              fallEdge,
  output logic              rstHit,
  output logic [SLOT_W-1:0] slotUs,
  output logic              driveLow,
  output logic              rxBitStb,
  output logic              rxBit,
  output logic              rxByteStb,
  output logic [DATA_W-1:0] rxByte
);

  localparam int LOW_W = $clog2(RST_US + 2);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [LOW_W-1:0] RST_LAST = LOW_W'(RST_US - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [1:0]        lineSync;
  logic              linePrev;
  logic [LOW_W-1:0]  lowUs;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextShift;

  // two-flop synchronizer, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSync <= 2'b11;
      linePrev <= 1'b1;
    end else begin
      lineSync <= {lineSync[0], lineIn};
      linePrev <= lineSync[1];
    end
  end

  assign lineLow  = ~lineSync[1];
  assign fallEdge = linePrev & ~lineSync[1];

  // microseconds the line has stayed low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lowUs <= '0;
    else if (!lineLow)              lowUs <= '0;
    else if (usTick && lowUs != '1) lowUs <= lowUs + 1'b1;
  end

  assign rstHit = usTick & lineLow & (lowUs == RST_LAST);

  // slot / presence timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       slotUs <= '0;
    else if (ctl.clrTimer)           slotUs <= '0;
    else if (usTick && slotUs != '1) slotUs <= slotUs + 1'b1;
  end

  // pull-down enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             driveLow <= 1'b0;
    else if (ctl.driveOff) driveLow <= 1'b0;
    else if (ctl.driveOn)  driveLow <= 1'b1;
  end

  assign nextShift = {lineSync[1], shiftReg[DATA_W-1:1]};

  // receive shifter, LSB arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx    <= '0;
      shiftReg  <= '0;
      rxByte    <= '0;
      rxBit     <= 1'b0;
      rxBitStb  <= 1'b0;
      rxByteStb <= 1'b0;
    end else begin
      rxBitStb  <= ctl.sample;
      rxByteStb <= 1'b0;
      if (ctl.clrByte) begin
        bitIdx <= '0;
      end else if (ctl.sample) begin
        rxBit    <= lineSync[1];
        shiftReg <= nextShift;
        if (bitIdx == IDX_LAST) begin
          bitIdx    <= '0;
          rxByte    <= nextShift;
          rxByteStb <= 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  p_byte_with_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxByteStb |-> rxBitStb);

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrByte |=> (bitIdx == '0));

  p_reset_once_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstHit |=> !rstHit);

endmodule

// File: rtl/swbus_slot_ctl.sv
module swbus_slot_ctl
  import swbus_pkg::*;
#(
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 15,
  parameter int SLOT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              txMode,
  input  logic              txBit,
  input  logic              lineLow,
  input  logic              fallEdge,
  input  logic              rstHit,
  input  logic [SLOT_W-1:0] slotUs,
  input  logic              driveLow,
  output ctlStrobe_t        ctl,
  output logic              txReq,
  output logic              rstSeen
);

  localparam logic [SLOT_W-1:0] PDW_LAST  = SLOT_W'(PD_WAIT_US - 1);
  localparam logic [SLOT_W-1:0] PDL_LAST  = SLOT_W'(PD_LOW_US - 1);
  localparam logic [SLOT_W-1:0] SMP_LAST  = SLOT_W'(SAMPLE_US - 1);
  localparam logic [SLOT_W-1:0] HOLD_LAST = SLOT_W'(HOLD_US - 1);

  slotState_t state, stateNext;
  logic       txReqNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    txReqNext = 1'b0;
    if (rstHit) begin
      stateNext    = ST_RSTWAIT;
      ctl.driveOff = 1'b1;
      ctl.clrByte  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (fallEdge) begin
          stateNext    = ST_QUAL;
          ctl.clrTimer = 1'b1;
        end
        ST_QUAL: begin
          if (!lineLow) begin
            stateNext = ST_IDLE;
          end else if (usTick) begin
            if (txMode) begin
              stateNext   = ST_RSLOT;
              txReqNext   = 1'b1;
              ctl.driveOn = ~txBit;
            end else begin
              stateNext = ST_WSLOT;
            end
          end
        end
        ST_WSLOT: if (usTick && slotUs == SMP_LAST) begin
          stateNext  = ST_WAITHI;
          ctl.sample = 1'b1;
        end
        ST_RSLOT: if (usTick && slotUs == HOLD_LAST) begin
          stateNext    = ST_WAITHI;
          ctl.driveOff = 1'b1;
        end
        ST_WAITHI: if (!lineLow) stateNext = ST_IDLE;
        ST_RSTWAIT: if (!lineLow) begin
          stateNext    = ST_PDWAIT;
          ctl.clrTimer = 1'b1;
        end
        ST_PDWAIT: if (usTick && slotUs == PDW_LAST) begin
          stateNext    = ST_PDLOW;
          ctl.clrTimer = 1'b1;
          ctl.driveOn  = 1'b1;
        end
        ST_PDLOW: if (usTick && slotUs == PDL_LAST) begin
          stateNext    = ST_WAITHI;
          ctl.driveOff = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      txReq   <= 1'b0;
      rstSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      txReq   <= txReqNext;
      rstSeen <= rstHit;
    end
  end

  p_drive_states_r5: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> (state == ST_RSLOT || state == ST_PDLOW));

  p_hold_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RSLOT) |-> (slotUs < SLOT_W'(HOLD_US)));

  p_presence_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PDLOW) |-> (slotUs < SLOT_W'(PD_LOW_US)));

  p_glitch_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_QUAL && !lineLow) |=> (state == ST_IDLE));

endmodule

// File: rtl/swbus_slot_slave.sv
module swbus_slot_slave
  import swbus_pkg::*;
#(
  parameter int RST_US     = 480,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 15,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              lineIn,
  input  logic              txMode,
  input  logic              txBit,
  output logic              pullN,
  output logic              rstSeen,
  output logic              txReq,
  output logic              rxBitStb,
  output logic              rxBit,
  output logic              rxByteStb,
  output logic [DATA_W-1:0] rxByte
);

  localparam int SPAN_US = PD_WAIT_US + PD_LOW_US + SAMPLE_US + HOLD_US;
  localparam int SLOT_W  = $clog2(SPAN_US + 2);

  ctlStrobe_t        ctl;
  logic              lineLow, fallEdge, rstHit, driveLow;
  logic [SLOT_W-1:0] slotUs;

  swbus_slot_ctl #(
    .PD_WAIT_US(PD_WAIT_US), .PD_LOW_US(PD_LOW_US),
    .SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US), .SLOT_W(SLOT_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .txMode(txMode), .txBit(txBit),
    .lineLow(lineLow), .fallEdge(fallEdge), .rstHit(rstHit), .slotUs(slotUs),
    .driveLow(driveLow), .ctl(ctl), .txReq(txReq), .rstSeen(rstSeen)
  );

  swbus_slot_dp #(
    .RST_US(RST_US), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineIn(lineIn), .ctl(ctl),
    .lineLow(lineLow), .fallEdge(fallEdge), .rstHit(rstHit), .slotUs(slotUs),
    .driveLow(driveLow), .rxBitStb(rxBitStb), .rxBit(rxBit),
    .rxByteStb(rxByteStb), .rxByte(rxByte)
  );

  assign pullN = ~driveLow;

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxBitStb, txReq, rstSeen}));

endmodule

// File: tb/sim_swbus_slot_slave.sv
module sim_swbus_slot_slave;

  localparam int US = 10; // clocks per microsecond tick

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic       hostLow = 1'b0;
  logic       txMode = 1'b0;
  logic       txBit = 1'b1;
  logic       pullN, rstSeen, txReq, rxBitStb, rxBit, rxByteStb;
  logic [7:0] rxByte;
  logic       wire_;

  int total = 0;
  int bad = 0;
  int bitCnt = 0, byteCnt = 0, reqCnt = 0, rstCnt = 0;
  bit finished = 0;

  assign wire_ = !(hostLow || !pullN);

  swbus_slot_slave u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineIn(wire_),
    .txMode(txMode), .txBit(txBit), .pullN(pullN), .rstSeen(rstSeen),
    .txReq(txReq), .rxBitStb(rxBitStb), .rxBit(rxBit),
    .rxByteStb(rxByteStb), .rxByte(rxByte)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (US - 1) @(negedge clk);
      usTick = 1'b1;
      @(negedge clk);
      usTick = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rxBitStb)  bitCnt++;
    if (rxByteStb) byteCnt++;
    if (txReq)     reqCnt++;
    if (rstSeen)   rstCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitUs(input int n);
    repeat (n * US) @(negedge clk);
  endtask

  task automatic writeBit(input bit b);
    hostLow = 1'b1;
    waitUs(b ? 6 : 80);
    hostLow = 1'b0;
    waitUs(b ? 84 : 10);
  endtask

  task automatic writeByte(input logic [7:0] v, input string req);
    int b0;
    b0 = bitCnt;
    for (int i = 0; i < 8; i++) begin
      writeBit(v[i]);
      check(rxBit == v[i], "R3", rxBit, v[i]);
    end
    check(bitCnt - b0 == 8, "R3", bitCnt - b0, 8);
    check(rxByte == v, req, rxByte, v);
  endtask

  task automatic testResetState();
    check(pullN == 1'b1, "R8", pullN, 1);
    check(rstCnt == 0 && bitCnt == 0, "R8", rstCnt + bitCnt, 0);
    check(reqCnt == 0 && byteCnt == 0, "R8", reqCnt + byteCnt, 0);
  endtask

  task automatic busReset();
    int r0, dly, wid;
    r0 = rstCnt;
    hostLow = 1'b1;
    waitUs(500);
    check(rstCnt - r0 == 1, "R1", rstCnt - r0, 1);
    hostLow = 1'b0;
    dly = 0;
    while (pullN && dly < 200 * US) begin @(negedge clk); dly++; end
    wid = 0;
    while (!pullN && wid < 400 * US) begin @(negedge clk); wid++; end
    check(dly >= 15 * US && dly <= 60 * US, "R2", dly / US, PDW_EXP);
    check(wid >= 60 * US && wid <= 240 * US, "R2", wid / US, 120);
    waitUs(10);
  endtask
  localparam int PDW_EXP = 30;

  task automatic testWrite();
    int y0;
    y0 = byteCnt;
    writeByte(8'hA5, "R4");
    writeByte(8'h01, "R4");
    check(byteCnt - y0 == 2, "R4", byteCnt - y0, 2);
  endtask

  task automatic readByte(input logic [7:0] v);
    int q0;
    q0 = reqCnt;
    txMode = 1'b1;
    for (int i = 0; i < 8; i++) begin
      txBit = v[i];
      hostLow = 1'b1;
      waitUs(2);
      hostLow = 1'b0;
      waitUs(11);  // 13 us after fall
      check(wire_ == v[i], "R5", wire_, v[i]);
      waitUs(4);   // 17 us after fall
      check(wire_ == 1'b1, "R5", wire_, 1);
      waitUs(50);
    end
    check(reqCnt - q0 == 8, "R5", reqCnt - q0, 8);
    txMode = 1'b0;
  endtask

  task automatic testGlitch();
    int b0, q0;
    bit sawPull;
    writeBit(1'b0);
    writeBit(1'b1);
    b0 = bitCnt;
    q0 = reqCnt;
    sawPull = 0;
    @(negedge clk);
    while (!usTick) @(negedge clk);
    @(negedge clk);
    hostLow = 1'b1;
    repeat (3) @(negedge clk);
    hostLow = 1'b0;
    repeat (30 * US) begin
      @(negedge clk);
      if (!pullN) sawPull = 1;
    end
    check(bitCnt == b0 && !sawPull, "R6", bitCnt - b0 + int'(sawPull), 0);
    check(reqCnt == q0, "R6", reqCnt - q0, 0);
    for (int i = 2; i < 8; i++) writeBit(i[0]);
    check(rxByte == 8'hAA, "R6", rxByte, 8'hAA);
  endtask

  task automatic testAbort();
    writeBit(1'b1);
    writeBit(1'b1);
    writeBit(1'b1);
    busReset();
    writeByte(8'h3C, "R7");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testResetState();
    busReset();
    testWrite();
    readByte(8'h96);
    testGlitch();
    testAbort();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule